// File: doc/BRIEF.md
# Four-Phase Machine-Cycle Sequencer

This block sets the timing for a small 4-bit controller core. Every instruction takes one machine cycle of four clock periods. A one-hot phase ring steps through them on falling clock edges. The output `sync_o` is low while the instruction is fetched and high while it is decoded. External inputs are captured on rising edges in fixed phases. The instruction register, program counter, skip flag and return stack change only at the end of set phases, and only while the sampled run input is asserted.

A skip condition set during one instruction turns the next fetch into a NOP (0x00). Jumps and calls take their target one phase after ordinary execution. A call pushes its return address before the jump lands. One output pin carries four status bits, one per phase. A captured two-bit select code, together with the bank field of the program counter, picks internal or external program memory. The ALU, data RAM and full instruction decode sit outside this block. Their results arrive as plain inputs (`skip_req_i`, `carry_i`, `bl13_i`, `d_drv_i`).

Top module: `seq_core`

## Requirements
- R1: `phase_o` is one-hot and steps T1 (bit0) → T3 (bit1) → T5 (bit2) → T7 (bit3) → T1, advancing on each falling clock edge. `sync_o` is 0 in T1/T3 and 1 in T5/T7.
- R2: While `rst_n` is low, the phase is T1 and PC, stack pointer, skip flag and IR are 0. After release the ring holds T1 for two more falling edges, then starts the first full cycle at T1.
- R3: `run_i` is sampled on the rising edge inside T3. In a cycle where the sampled value is 0, IR, PC, stack pointer and skip flag keep their values and `exec_o` stays 0.
- R4: `k_i` is sampled on the rising edge inside T5 and `i_i` on the rising edge inside T7. `k_o` and `i_o` hold the sampled values for the rest of the machine cycle.
- R5: At the end of a running T3, IR loads `rom_data_i` (addressed by `pc_o`), or 0x00 if the skip flag is set.
- R6: At the end of a running T5, PC increments by one. The skip flag becomes 1 for an RTS, `skip_req_i` for an ordinary instruction, and 0 for NOP, JMP, JMS and RT. `exec_o` is high during a running T5 unless IR is JMP, RT or RTS.
- R7: IR encoding `11aaaaaa` is JMP and `10aaaaaa` is JMS. At the end of a running T7 either one loads PC with {`bank_i`, `page_i`, aaaaaa}.
- R8: JMS increments the stack pointer at the end of T5 and saves PC+1 at the new top. RT (0x01) and RTS (0x02) reload PC from the top and decrement the stack pointer at the end of T7.
- R9: `status_o` is NOT `d_drv_i` in T1, `bl13_i` in T3, `carry_i` in T5 and the skip flag in T7.
- R10: `rom_sel_i` is captured at the end of T1 and at the end of T5 only.
- R11: `int_rom_o` is 1 for captured code 00 only when the PC bank field (bits 12:10) is 0. It is 0 for code 01 and 1 for codes 10 and 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| run_i | input | 1 | Run enable, sampled in T3 |
| k_i | input | 4 | Key inputs, sampled in T5 |
| i_i | input | 4 | General inputs, sampled in T7 |
| rom_sel_i | input | 2 | Program memory select code |
| rom_data_i | input | 8 | Instruction byte at `pc_o` |
| bank_i | input | 3 | Prepared bank for jumps |
| page_i | input | 4 | Prepared page for jumps |
| skip_req_i | input | 1 | Skip condition from the datapath |
| d_drv_i | input | 1 | D outputs are driven |
| bl13_i | input | 1 | BL register equals 13 |
| carry_i | input | 1 | Carry flag |
| phase_o | output | 4 | One-hot phase (T1..T7) |
| sync_o | output | 1 | Fetch (0) / decode (1) half |
| k_o | output | 4 | Sampled key inputs |
| i_o | output | 4 | Sampled general inputs |
| pc_o | output | 13 | Program counter / memory address |
| ir_o | output | 8 | Instruction register |
| sp_o | output | 2 | Return stack pointer |
| skip_o | output | 1 | Skip flag |
| exec_o | output | 1 | Datapath commit strobe for end of T5 |
| status_o | output | 1 | Phase-multiplexed status bit |
| int_rom_o | output | 1 | Internal program memory selected |

## Verification
A short program is run in which ordinary instructions, a skip-raising instruction, a skipped jump, nested call/return pairs and an RTS follow each other. The program counter and stack pointer show whether a skipped jump was really suppressed, and whether a return uses the address saved by its call. Run is dropped in T3 only, and then held only in T3. This shows that the T3 sample gates the cycle, not the level in other phases. Key, general, status and select inputs change in every phase, so a capture or mux slot that is off by one phase gives a different value at the port.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int NPH   = 4;
  localparam int PH_T1 = 0;
  localparam int PH_T3 = 1;
  localparam int PH_T5 = 2;
  localparam int PH_T7 = 3;

  typedef enum logic [2:0] {
    CL_NOP, CL_PLAIN, CL_JMP, CL_JMS, CL_RET, CL_RTS
  } op_class_e;

  typedef enum logic [1:0] {
    RS_BANK0 = 2'b00,
    RS_EXT   = 2'b01,
    RS_TEST  = 2'b10,
    RS_INT   = 2'b11
  } rom_sel_e;
endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/seq_ring.sv
module seq_ring #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         srst_n,
  output logic [N-1:0] phase_o
);
  logic [N-1:0] ph_q, ph_d;

  always_comb ph_d = {ph_q[N-2:0], ph_q[N-1]};

  always_ff @(negedge clk or negedge srst_n) begin
    if (!srst_n) ph_q <= N'(1);
    else         ph_q <= ph_d;
  end

  assign phase_o = ph_q;
endmodule

// File: rtl/seq_decode.sv
module seq_decode
  import seq_pkg::*;
#(
  parameter int IW = 8,
  parameter int AW = 6
) (
  input  logic [IW-1:0] ir_i,
  output op_class_e     cls_o,
  output logic [AW-1:0] addr_o
);
  localparam logic [IW-1:0] OP_RT  = IW'(1);
  localparam logic [IW-1:0] OP_RTS = IW'(2);

  always_comb begin
    if (ir_i[IW-1:IW-2] == 2'b11)      cls_o = CL_JMP;
    else if (ir_i[IW-1:IW-2] == 2'b10) cls_o = CL_JMS;
    else if (ir_i == '0)               cls_o = CL_NOP;
    else if (ir_i == OP_RT)            cls_o = CL_RET;
    else if (ir_i == OP_RTS)           cls_o = CL_RTS;
    else                               cls_o = CL_PLAIN;
  end

  assign addr_o = ir_i[AW-1:0];
endmodule

// File: rtl/seq_pins.sv
module seq_pins
  import seq_pkg::*;
#(
  parameter int BW = 3
) (
  input  logic [NPH-1:0] phase_i,
  input  logic           d_drv_i,
  input  logic           bl13_i,
  input  logic           carry_i,
  input  logic           skip_i,
  input  logic [1:0]     sel_i,
  input  logic [BW-1:0]  bank_i,
  output logic           status_o,
  output logic           int_rom_o
);
  always_comb begin
    status_o = (phase_i[PH_T1] & ~d_drv_i) |
               (phase_i[PH_T3] &  bl13_i)  |
               (phase_i[PH_T5] &  carry_i) |
               (phase_i[PH_T7] &  skip_i);
  end

  always_comb begin
    case (rom_sel_e'(sel_i))
      RS_BANK0: int_rom_o = (bank_i == '0);
      RS_EXT:   int_rom_o = 1'b0;
      default:  int_rom_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/seq_core.sv
module seq_core
  import seq_pkg::*;
#(
  parameter  int IW     = 8,
  parameter  int AW     = 6,
  parameter  int PW     = 4,
  parameter  int BW     = 3,
  parameter  int KW     = 4,
  parameter  int SPW    = 2,
  localparam int PCW    = AW + PW + BW,
  localparam int SDEPTH = 1 << SPW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_i,
  input  logic [KW-1:0]   k_i,
  input  logic [KW-1:0]   i_i,
  input  logic [1:0]      rom_sel_i,
  input  logic [IW-1:0]   rom_data_i,
  input  logic [BW-1:0]   bank_i,
  input  logic [PW-1:0]   page_i,
  input  logic            skip_req_i,
  input  logic            d_drv_i,
  input  logic            bl13_i,
  input  logic            carry_i,
  output logic [NPH-1:0]  phase_o,
  output logic            sync_o,
  output logic [KW-1:0]   k_o,
  output logic [KW-1:0]   i_o,
  output logic [PCW-1:0]  pc_o,
  output logic [IW-1:0]   ir_o,
  output logic [SPW-1:0]  sp_o,
  output logic            skip_o,
  output logic            exec_o,
  output logic            status_o,
  output logic            int_rom_o
);
  logic            srst_n;
  logic [NPH-1:0]  phase;
  logic            run_q;
  logic [KW-1:0]   k_q, i_q;
  logic [1:0]      sel_q;
  logic            sel_en;
  logic [IW-1:0]   ir_q, ir_d;
  logic            ir_en;
  logic [PCW-1:0]  pc_q, pc_d, pc_inc;
  logic [SPW-1:0]  sp_q, sp_d, sp_inc;
  logic            skip_q, skip_d;
  logic            push_en;
  logic [PCW-1:0]  stk_q [SDEPTH];
  op_class_e       cls;
  logic [AW-1:0]   tgt_addr;
  logic            is_flow;

  seq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  seq_ring #(.N(NPH)) u_ring (.clk(clk), .srst_n(srst_n), .phase_o(phase));

  seq_decode #(.IW(IW), .AW(AW)) u_dec (.ir_i(ir_q), .cls_o(cls), .addr_o(tgt_addr));

  seq_pins #(.BW(BW)) u_pins (
    .phase_i(phase), .d_drv_i(d_drv_i), .bl13_i(bl13_i), .carry_i(carry_i),
    .skip_i(skip_q), .sel_i(sel_q), .bank_i(pc_q[PCW-1 -: BW]),
    .status_o(status_o), .int_rom_o(int_rom_o)
  );

  // input sampling on rising edges, one phase each
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)             run_q <= 1'b0;
    else if (phase[PH_T3])   run_q <= run_i;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)             k_q <= '0;
    else if (phase[PH_T5])   k_q <= k_i;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)             i_q <= '0;
    else if (phase[PH_T7])   i_q <= i_i;
  end

  // memory select capture, mid-fetch and mid-decode
  assign sel_en = phase[PH_T1] | phase[PH_T5];

  always_ff @(negedge clk or negedge srst_n) begin
    if (!srst_n)     sel_q <= 2'b00;
    else if (sel_en) sel_q <= rom_sel_i;
  end

  // fetch at end of T3
  assign ir_en = run_q & phase[PH_T3];
  assign ir_d  = skip_q ? '0 : rom_data_i;

  always_ff @(negedge clk or negedge srst_n) begin
    if (!srst_n)    ir_q <= '0;
    else if (ir_en) ir_q <= ir_d;
  end

  // control flow next state
  assign pc_inc  = pc_q + PCW'(1);
  assign sp_inc  = sp_q + SPW'(1);
  assign is_flow = (cls == CL_JMP) | (cls == CL_RET) | (cls == CL_RTS);

  always_comb begin
    pc_d    = pc_q;
    sp_d    = sp_q;
    skip_d  = skip_q;
    push_en = 1'b0;
    if (run_q && phase[PH_T5]) begin
      pc_d   = pc_inc;
      skip_d = (cls == CL_RTS) | ((cls == CL_PLAIN) & skip_req_i);
      if (cls == CL_JMS) begin
        sp_d    = sp_inc;
        push_en = 1'b1;
      end
    end
    if (run_q && phase[PH_T7]) begin
      if (cls == CL_JMP || cls == CL_JMS) begin
        pc_d = {bank_i, page_i, tgt_addr};
      end else if (cls == CL_RET || cls == CL_RTS) begin
        pc_d = stk_q[sp_q];
        sp_d = sp_q - SPW'(1);
      end
    end
  end

  always_ff @(negedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pc_q   <= '0;
      sp_q   <= '0;
      skip_q <= 1'b0;
    end else begin
      pc_q   <= pc_d;
      sp_q   <= sp_d;
      skip_q <= skip_d;
    end
  end

  always_ff @(negedge clk or negedge srst_n) begin
    if (!srst_n) begin
      for (int e = 0; e < SDEPTH; e++) stk_q[e] <= '0;
    end else if (push_en) begin
      stk_q[sp_inc] <= pc_inc;
    end
  end

  assign phase_o = phase;
  assign sync_o  = phase[PH_T5] | phase[PH_T7];
  assign k_o     = k_q;
  assign i_o     = i_q;
  assign pc_o    = pc_q;
  assign ir_o    = ir_q;
  assign sp_o    = sp_q;
  assign skip_o  = skip_q;
  assign exec_o  = run_q & phase[PH_T5] & ~is_flow;
endmodule

// File: rtl/seq_core_chk.sv
module seq_core_chk #(
  parameter int PCW = 13,
  parameter int SPW = 2,
  parameter int IW  = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           srst_n,
  input logic [3:0]     phase,
  input logic           run_q,
  input logic [PCW-1:0] pc,
  input logic [SPW-1:0] sp,
  input logic [IW-1:0]  ir,
  input logic           skip,
  input logic           exec
);
  function automatic logic [3:0] rot(input logic [3:0] p);
    return {p[2:0], p[3]};
  endfunction

  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(phase) == 1);

  a_r1_ring_step: assert property (@(posedge clk) disable iff (!rst_n)
    srst_n |=> phase == rot($past(phase)));

  a_r3_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_n && phase[2] && !run_q) |=> ($stable(pc) && $stable(sp) && $stable(skip)));

  a_r5_skip_gives_nop: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_n && phase[2] && run_q && skip) |-> ir == '0);

  a_r6_pc_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_n && phase[2] && run_q) |=> pc == PCW'($past(pc) + 1'b1));

  a_r6_exec_window: assert property (@(posedge clk) disable iff (!rst_n)
    exec |-> (phase[2] && run_q));

  a_r8_call_push: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_n && phase[2] && run_q && ir[IW-1:IW-2] == 2'b10) |=> sp == SPW'($past(sp) + 1'b1));
endmodule

bind seq_core seq_core_chk #(.PCW(PCW), .SPW(SPW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .srst_n(srst_n), .phase(phase_o), .run_q(run_q),
  .pc(pc_o), .sp(sp_o), .ir(ir_o), .skip(skip_o), .exec(exec_o)
);

// File: tb/tb_seq_core.sv
`timescale 1ns/1ps
module tb_seq_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        run_i;
  logic [3:0]  k_i, i_i;
  logic [1:0]  rom_sel_i;
  logic [7:0]  rom_data_i;
  logic [2:0]  bank_i;
  logic [3:0]  page_i;
  logic        skip_req_i, d_drv_i, bl13_i, carry_i;
  logic [3:0]  phase_o;
  logic        sync_o;
  logic [3:0]  k_o, i_o;
  logic [12:0] pc_o;
  logic [7:0]  ir_o;
  logic [1:0]  sp_o;
  logic        skip_o, exec_o, status_o, int_rom_o;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  seq_core dut (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .k_i(k_i), .i_i(i_i),
    .rom_sel_i(rom_sel_i), .rom_data_i(rom_data_i), .bank_i(bank_i), .page_i(page_i),
    .skip_req_i(skip_req_i), .d_drv_i(d_drv_i), .bl13_i(bl13_i), .carry_i(carry_i),
    .phase_o(phase_o), .sync_o(sync_o), .k_o(k_o), .i_o(i_o), .pc_o(pc_o),
    .ir_o(ir_o), .sp_o(sp_o), .skip_o(skip_o), .exec_o(exec_o),
    .status_o(status_o), .int_rom_o(int_rom_o)
  );

  function automatic logic [7:0] rom_f(input logic [12:0] a);
    case (a)
      13'h000: return 8'h20;
      13'h001: return 8'h21;
      13'h002: return 8'hC9;
      13'h003: return 8'h90;
      13'h010: return 8'h01;
      13'h004: return 8'h94;
      13'h014: return 8'h02;
      13'h005: return 8'hC0;
      13'h006: return 8'hE0;
      13'h060: return 8'hC5;
      default: return 8'h20;
    endcase
  endfunction

  always_comb rom_data_i = rom_f(pc_o);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic next_phase();
    @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; run_i = 1'b0; k_i = '0; i_i = '0; rom_sel_i = 2'b00;
    bank_i = '0; page_i = '0; skip_req_i = 0; d_drv_i = 0; bl13_i = 0; carry_i = 0;
    #13;
    next_phase();
    chk("R2", "phase", phase_o, 4'b0001);
    chk("R2", "pc", pc_o, 0);
    chk("R2", "sp", sp_o, 0);
    chk("R2", "skip", skip_o, 0);
    chk("R2", "ir", ir_o, 0);
    chk("R11", "int_rom code00 bank0", int_rom_o, 1);
    rst_n = 1'b1;
    next_phase();
    next_phase();
    chk("R2", "phase held T1 after release", phase_o, 4'b0001);
  endtask

  task automatic t_ring_stopped();
    // run_i low: ring cycles, nothing else moves
    next_phase(); chk("R1", "T3", phase_o, 4'b0010); chk("R1", "sync T3", sync_o, 0);
    next_phase(); chk("R1", "T5", phase_o, 4'b0100); chk("R1", "sync T5", sync_o, 1);
    chk("R3", "exec stopped", exec_o, 0);
    next_phase(); chk("R1", "T7", phase_o, 4'b1000); chk("R1", "sync T7", sync_o, 1);
    next_phase(); chk("R1", "back T1", phase_o, 4'b0001); chk("R1", "sync T1", sync_o, 0);
    chk("R3", "pc stopped", pc_o, 0);
    chk("R3", "ir stopped", ir_o, 0);
  endtask

  task automatic exec_cycle(input string req, input logic sk, input logic [7:0] eir,
                            input logic eexec, input logic [12:0] epc,
                            input logic [1:0] esp, input logic eskip);
    skip_req_i = sk;
    next_phase();
    next_phase();
    chk(req, "ir", ir_o, eir);
    chk(req, "exec", exec_o, eexec);
    next_phase();
    next_phase();
    chk(req, "pc", pc_o, epc);
    chk(req, "sp", sp_o, esp);
    chk(req, "skip", skip_o, eskip);
    skip_req_i = 0;
  endtask

  task automatic t_program();
    run_i = 1'b1;
    exec_cycle("R6",  0, 8'h20, 1, 13'h001, 0, 0);
    exec_cycle("R6",  1, 8'h21, 1, 13'h002, 0, 1);
    exec_cycle("R5",  1, 8'h00, 1, 13'h003, 0, 0);  // skipped JMP becomes NOP, skip_req ignored
    exec_cycle("R7",  0, 8'h90, 1, 13'h010, 1, 0);  // JMS 0x10
    exec_cycle("R8",  1, 8'h01, 0, 13'h004, 0, 0);  // RT
    exec_cycle("R8",  0, 8'h94, 1, 13'h014, 1, 0);  // JMS 0x14
    exec_cycle("R8",  0, 8'h02, 0, 13'h005, 0, 1);  // RTS sets skip
    exec_cycle("R5",  0, 8'h00, 1, 13'h006, 0, 0);  // skipped JMP
    page_i = 4'd1;
    exec_cycle("R7",  0, 8'hE0, 0, 13'h060, 0, 0);
    bank_i = 3'd1; page_i = 4'd2;
    exec_cycle("R7",  0, 8'hC5, 0, 13'h485, 0, 0);
    bank_i = '0; page_i = '0;
    chk("R11", "int_rom code00 bank1", int_rom_o, 0);
  endtask

  task automatic t_run_gate();
    run_i = 1;
    next_phase(); run_i = 0;
    next_phase(); run_i = 1;
    chk("R3", "no fetch ir", ir_o, 8'hC5);
    chk("R3", "no exec", exec_o, 0);
    next_phase();
    next_phase();
    chk("R3", "pc held", pc_o, 13'h485);
    run_i = 0;
    next_phase(); run_i = 1;
    next_phase(); run_i = 0;
    chk("R3", "fetch from T3 sample", ir_o, 8'h20);
    chk("R3", "exec from T3 sample", exec_o, 1);
    next_phase();
    next_phase();
    chk("R3", "pc advanced", pc_o, 13'h486);
    run_i = 1;
  endtask

  task automatic t_sample_kin();
    k_i = 4'h1; i_i = 4'h1;
    next_phase(); k_i = 4'h2; i_i = 4'h2;
    next_phase(); k_i = 4'h3; i_i = 4'h3;
    next_phase();
    chk("R4", "k after T5", k_o, 4'h3);
    chk("R4", "i held", i_o, 4'h0);
    k_i = 4'h4; i_i = 4'h4;
    next_phase();
    chk("R4", "i after T7", i_o, 4'h4);
    chk("R4", "k held", k_o, 4'h3);
    k_i = 4'h5; i_i = 4'h5;
  endtask

  task automatic t_status(input logic sk, input logic drv, input logic bl, input logic cy, input logic eskip);
    skip_req_i = sk;
    d_drv_i = drv; #0.5;
    chk("R9", "status T1", status_o, !drv);
    next_phase(); bl13_i = bl; #0.5;
    chk("R9", "status T3", status_o, bl);
    next_phase(); carry_i = cy; #0.5;
    chk("R9", "status T5", status_o, cy);
    next_phase(); #0.5;
    chk("R9", "status T7", status_o, eskip);
    next_phase();
    skip_req_i = 0;
  endtask

  task automatic t_romsel();
    rom_sel_i = 2'b01;
    next_phase(); chk("R10", "T1 capture 01", int_rom_o, 0);
    rom_sel_i = 2'b11;
    next_phase(); chk("R10", "no T3 capture", int_rom_o, 0);
    next_phase(); chk("R10", "T5 capture 11", int_rom_o, 1);
    rom_sel_i = 2'b01;
    next_phase(); chk("R10", "no T7 capture", int_rom_o, 1);
    rom_sel_i = 2'b00;
    next_phase(); chk("R11", "code00 bank1", int_rom_o, 0);
    rom_sel_i = 2'b10;
    next_phase(); chk("R11", "held before T5", int_rom_o, 0);
    next_phase(); chk("R11", "code10", int_rom_o, 1);
    rom_sel_i = 2'b00;
    next_phase();
  endtask

  initial begin
    t_reset();
    t_ring_stopped();
    t_program();
    t_run_gate();
    t_sample_kin();
    t_status(0, 1, 1, 1, 0);
    t_status(1, 0, 0, 0, 1);
    t_romsel();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #500000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule